// File: doc/BRIEF.md
# Flash Card Memory-Mode Cycle Engine

This block sits on the host side of a removable flash card that is run in its RAM-like memory mode. A client hands it one request at a time over a valid/ready handshake. Each request carries an 11-bit card address, a space select (common or attribute), a byte-or-word flag and 16 bits of write data. The engine then runs one complete bus cycle. It drives the address, the two active-low chip enables, the register-select line and either the read strobe or the write strobe. Setup, strobe and hold lengths are counted in clock cycles and come from configuration inputs. A read returns its data together with a one-cycle done pulse, and a write also ends with that pulse.

On reset the engine holds the card's active-high reset pin high for a fixed number of cycles. It then waits for the card's ready output before it accepts any work. The card's active-low wait output can stretch a strobe. Attribute-space cycles take their strobe length from their own configuration input, so that the slower access of that space can be met. Single-byte transfers always use the low data lane, and the card steers the even or odd byte onto that lane.

State machine: `ST_CARD_RST` (card reset held) goes to `ST_BOOT` when the reset count expires. `ST_BOOT` goes to `ST_IDLE` once the card reports ready. `ST_IDLE` goes to `ST_SETUP` when a request is accepted. `ST_SETUP` goes to `ST_STROBE` after the setup count. `ST_STROBE` goes to `ST_HOLD` after the strobe count, provided the wait line is high. `ST_HOLD` goes to `ST_IDLE` after the hold count, and that step produces the done pulse.

Top module: `cfmem_engine`

## Requirements
- R1: After `rst_n` rises, `cf_reset` stays high and falls at the RESET_CYCLES-th rising clock edge. While it is high, both chip enables and both strobes stay inactive (high).
- R2: While `cf_ready` is low, `req_ready` is low and no chip enable or strobe goes active. This holds in the boot phase and later in idle.
- R3: `req_ready` is high only while idle with the card ready. A request offered during a cycle is refused. Address, chip enables and register select keep the accepted values for the whole cycle.
- R4: `cf_reg_n` is high during common-space cycles and low during attribute-space cycles.
- R5: A word access drives both chip enables low, with address bit 0 forced to 0. A byte access drives `cf_ce1_n` low and `cf_ce2_n` high, with address bit 0 equal to `req_addr[0]` (0 = even byte, 1 = odd byte).
- R6: Chip enables and address are active for max(`cfg_setup`,1) cycles before the strobe falls.
- R7: Without wait, the strobe lasts max(`cfg_strobe_com`,1) cycles in common space and max(`cfg_strobe_attr`,1) cycles in attribute space.
- R8: A strobe ends only on a rising edge at which `cf_wait_n` is high. If wait is held low through the first W strobe cycles, the strobe lasts max(S,W+1) cycles, where S is its length from R7.
- R9: Chip enables and address remain active for max(`cfg_hold`,1) cycles after the strobe rises.
- R10: A read uses `cf_oe_n` alone. The data is captured on the edge that releases the strobe: a word read returns D15:D0, and a byte read returns {8'h00, D7:D0}. `rsp_done` is high for exactly one cycle, the first idle cycle after the hold.
- R11: A write uses `cf_we_n` alone. `cf_d_oe` is high exactly while `cf_we_n` is low. It drives `req_wdata` for a word, and {8'h00, `req_wdata[7:0]`} for a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_attr | input | 1 | 1 = attribute space, 0 = common space |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_addr | input | 11 | Card address |
| req_wdata | input | 16 | Write data |
| cfg_setup | input | CNT_W | Setup cycles (0 treated as 1) |
| cfg_strobe_com | input | CNT_W | Common-space strobe cycles |
| cfg_strobe_attr | input | CNT_W | Attribute-space strobe cycles |
| cfg_hold | input | CNT_W | Hold cycles |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, held until the next read |
| cf_reset | output | 1 | Card reset, active high |
| cf_ready | input | 1 | Card ready (low = busy) |
| cf_wait_n | input | 1 | Card wait, active low |
| cf_addr | output | 11 | Card address lines |
| cf_ce1_n | output | 1 | Chip enable 1, active low |
| cf_ce2_n | output | 1 | Chip enable 2 (odd byte), active low |
| cf_reg_n | output | 1 | Space select: high common, low attribute |
| cf_oe_n | output | 1 | Read strobe, active low |
| cf_we_n | output | 1 | Write strobe, active low |
| cf_d_out | output | 16 | Data toward the card |
| cf_d_oe | output | 1 | Data driver enable |
| cf_d_in | input | 16 | Data from the card |

## Verification
The assertions assume that `cf_ready` and `cf_wait_n` are already synchronous to `clk`. They also assume that the configuration inputs stay constant while a cycle is in progress. The bench changes the configuration only between cycles, and it moves the wait and ready lines only on falling edges. Its wait line goes low only inside a strobe, with a run length drawn at random, so the stretch rule is exercised both shorter and longer than the configured strobe. Its card model answers reads according to the chip-enable and A0 decoding. The random traffic comes from a fixed seed and mixes spaces, widths, directions and zero-valued configuration counts.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

    localparam int CFM_AW = 11;
    localparam int CFM_DW = 16;
    localparam int CFM_BW = 8;

    typedef enum logic [2:0] {
        ST_CARD_RST,
        ST_BOOT,
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD
    } cfm_state_t;

    typedef struct packed {
        logic              write;
        logic              attr;
        logic              word;
        logic [CFM_AW-1:0] addr;
        logic [CFM_DW-1:0] wdata;
    } cfm_req_t;

endpackage

// File: rtl/cfm_power_gate.sv
module cfm_power_gate #(
    parameter int RESET_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic card_reset
);
    localparam int RW = $clog2(RESET_CYCLES + 1);
    localparam logic [RW-1:0] LIMIT = RW'(RESET_CYCLES);

    logic [RW-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (count_q != LIMIT) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign card_reset = (count_q != LIMIT);

    // R1: once released, the card reset never comes back without a reset of the block
    p_reset_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !card_reset |=> !card_reset);

endmodule

// File: rtl/cfm_lane_map.sv
module cfm_lane_map
    import cfm_pkg::*;
(
    input  cfm_req_t           cur_req,
    input  logic [CFM_DW-1:0]  bus_din,
    output logic               lane_ce1_n,
    output logic               lane_ce2_n,
    output logic [CFM_AW-1:0]  lane_addr,
    output logic [CFM_DW-1:0]  lane_dout,
    output logic [CFM_DW-1:0]  lane_rword
);
    localparam logic [CFM_BW-1:0] ZERO_BYTE = '0;

    always_comb begin
        lane_ce1_n = 1'b0;
        if (cur_req.word) begin
            lane_ce2_n = 1'b0;
            lane_addr  = {cur_req.addr[CFM_AW-1:1], 1'b0};
            lane_dout  = cur_req.wdata;
            lane_rword = bus_din;
        end else begin
            lane_ce2_n = 1'b1;
            lane_addr  = cur_req.addr;
            lane_dout  = {ZERO_BYTE, cur_req.wdata[CFM_BW-1:0]};
            lane_rword = {ZERO_BYTE, bus_din[CFM_BW-1:0]};
        end
    end

endmodule

// File: rtl/cfm_cycle_seq.sv
module cfm_cycle_seq
    import cfm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               card_reset,
    input  logic               cf_ready,
    input  logic               cf_wait_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  cfm_req_t           req_in,
    input  logic [CNT_W-1:0]   cfg_setup,
    input  logic [CNT_W-1:0]   cfg_strobe_com,
    input  logic [CNT_W-1:0]   cfg_strobe_attr,
    input  logic [CNT_W-1:0]   cfg_hold,
    output cfm_req_t           cur_req,
    input  logic               lane_ce1_n,
    input  logic               lane_ce2_n,
    input  logic [CFM_DW-1:0]  lane_rword,
    output logic               cf_ce1_n,
    output logic               cf_ce2_n,
    output logic               cf_reg_n,
    output logic               cf_oe_n,
    output logic               cf_we_n,
    output logic               cf_d_oe,
    output logic               rsp_done,
    output logic [CFM_DW-1:0]  rsp_rdata
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cfm_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  phase_len;
    logic              phase_done;
    logic              accept;
    logic              bus_active;

    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? ONE : v;
    endfunction

    assign req_ready = (state_q == ST_IDLE) && cf_ready;
    assign accept    = req_valid && req_ready;

    always_comb begin
        unique case (state_q)
            ST_SETUP:  phase_len = at_least_one(cfg_setup);
            ST_STROBE: phase_len = cur_req.attr ? at_least_one(cfg_strobe_attr)
                                                : at_least_one(cfg_strobe_com);
            ST_HOLD:   phase_len = at_least_one(cfg_hold);
            default:   phase_len = ONE;
        endcase
    end

    assign phase_done = (cnt_q >= phase_len);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CARD_RST: if (!card_reset)              state_d = ST_BOOT;
            ST_BOOT:     if (cf_ready)                 state_d = ST_IDLE;
            ST_IDLE:     if (accept)                   state_d = ST_SETUP;
            ST_SETUP:    if (phase_done)               state_d = ST_STROBE;
            ST_STROBE:   if (phase_done && cf_wait_n)  state_d = ST_HOLD;
            ST_HOLD:     if (phase_done)               state_d = ST_IDLE;
            default:                                   state_d = ST_CARD_RST;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CARD_RST;
        end else begin
            state_q <= state_d;
        end
    end

    // phase counter, request latch and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= ONE;
            cur_req   <= '0;
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            if (accept) begin
                cur_req <= req_in;
            end
            if (state_d != state_q) begin
                cnt_q <= ONE;
            end else if (cnt_q < phase_len) begin
                cnt_q <= cnt_q + ONE;
            end
            rsp_done <= (state_q == ST_HOLD) && (state_d == ST_IDLE);
            if ((state_q == ST_STROBE) && (state_d == ST_HOLD) && !cur_req.write) begin
                rsp_rdata <= lane_rword;
            end
        end
    end

    // bus outputs
    always_comb begin
        bus_active = 1'b0;
        cf_oe_n    = 1'b1;
        cf_we_n    = 1'b1;
        cf_d_oe    = 1'b0;
        unique case (state_q)
            ST_SETUP, ST_HOLD: bus_active = 1'b1;
            ST_STROBE: begin
                bus_active = 1'b1;
                cf_oe_n    = cur_req.write;
                cf_we_n    = !cur_req.write;
                cf_d_oe    = cur_req.write;
            end
            default: bus_active = 1'b0;
        endcase
        cf_ce1_n = bus_active ? lane_ce1_n : 1'b1;
        cf_ce2_n = bus_active ? lane_ce2_n : 1'b1;
        cf_reg_n = bus_active ? !cur_req.attr : 1'b1;
    end

    logic strobe_n;
    assign strobe_n = cf_oe_n && cf_we_n;

    // R1: the card bus is idle while the card is held in reset
    p_quiet_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        card_reset |-> (cf_ce1_n && cf_ce2_n && strobe_n));

    // R2: no cycle is started from idle while the card reports busy
    p_no_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && !cf_ready) |=> cf_ce1_n);

    // R3: bus controls held steady through a cycle
    p_held_controls_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cf_ce1_n && $past(!cf_ce1_n)) |-> ($stable(cf_reg_n) && $stable(cf_ce2_n) && $stable(cur_req)));

    // R6: a strobe only falls after the chip enable was already active
    p_setup_before_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_n) |-> $past(!cf_ce1_n));

    // R8: a low wait line keeps the strobe active into the next cycle
    p_wait_stretch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n && !cf_wait_n) |=> !strobe_n);

    // R9: chip enable still active right after the strobe rises
    p_hold_after_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_n) |-> !cf_ce1_n);

    // R10: done is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R11: never both strobes, and data driven only inside an enabled cycle
    p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cf_oe_n || cf_we_n));
    p_drive_in_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cf_d_oe |-> (!cf_ce1_n && !cf_we_n));

endmodule

// File: rtl/cfmem_engine.sv
module cfmem_engine
    import cfm_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int RESET_CYCLES = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic                req_attr,
    input  logic                req_word,
    input  logic [CFM_AW-1:0]   req_addr,
    input  logic [CFM_DW-1:0]   req_wdata,
    input  logic [CNT_W-1:0]    cfg_setup,
    input  logic [CNT_W-1:0]    cfg_strobe_com,
    input  logic [CNT_W-1:0]    cfg_strobe_attr,
    input  logic [CNT_W-1:0]    cfg_hold,
    output logic                rsp_done,
    output logic [CFM_DW-1:0]   rsp_rdata,
    output logic                cf_reset,
    input  logic                cf_ready,
    input  logic                cf_wait_n,
    output logic [CFM_AW-1:0]   cf_addr,
    output logic                cf_ce1_n,
    output logic                cf_ce2_n,
    output logic                cf_reg_n,
    output logic                cf_oe_n,
    output logic                cf_we_n,
    output logic [CFM_DW-1:0]   cf_d_out,
    output logic                cf_d_oe,
    input  logic [CFM_DW-1:0]   cf_d_in
);
    cfm_req_t           req_in;
    cfm_req_t           cur_req;
    logic               lane_ce1_n;
    logic               lane_ce2_n;
    logic [CFM_DW-1:0]  lane_rword;

    assign req_in = '{write: req_write, attr: req_attr, word: req_word,
                      addr: req_addr, wdata: req_wdata};

    cfm_power_gate #(
        .RESET_CYCLES (RESET_CYCLES)
    ) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .card_reset (cf_reset)
    );

    cfm_lane_map u_lanes (
        .cur_req    (cur_req),
        .bus_din    (cf_d_in),
        .lane_ce1_n (lane_ce1_n),
        .lane_ce2_n (lane_ce2_n),
        .lane_addr  (cf_addr),
        .lane_dout  (cf_d_out),
        .lane_rword (lane_rword)
    );

    cfm_cycle_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .card_reset      (cf_reset),
        .cf_ready        (cf_ready),
        .cf_wait_n       (cf_wait_n),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_in          (req_in),
        .cfg_setup       (cfg_setup),
        .cfg_strobe_com  (cfg_strobe_com),
        .cfg_strobe_attr (cfg_strobe_attr),
        .cfg_hold        (cfg_hold),
        .cur_req         (cur_req),
        .lane_ce1_n      (lane_ce1_n),
        .lane_ce2_n      (lane_ce2_n),
        .lane_rword      (lane_rword),
        .cf_ce1_n        (cf_ce1_n),
        .cf_ce2_n        (cf_ce2_n),
        .cf_reg_n        (cf_reg_n),
        .cf_oe_n         (cf_oe_n),
        .cf_we_n         (cf_we_n),
        .cf_d_oe         (cf_d_oe),
        .rsp_done        (rsp_done),
        .rsp_rdata       (rsp_rdata)
    );

endmodule

// File: tb/cfmem_engine_tb.sv
module cfmem_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RST_CYC    = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_attr = 1'b0;
    logic        req_word = 1'b0;
    logic [10:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [7:0]  cfg_setup = 8'd1;
    logic [7:0]  cfg_strobe_com = 8'd2;
    logic [7:0]  cfg_strobe_attr = 8'd30;
    logic [7:0]  cfg_hold = 8'd1;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic        cf_reset;
    logic        cf_ready = 1'b0;
    logic        cf_wait_n = 1'b1;
    logic [10:0] cf_addr;
    logic        cf_ce1_n, cf_ce2_n, cf_reg_n, cf_oe_n, cf_we_n;
    logic [15:0] cf_d_out;
    logic        cf_d_oe;
    logic [15:0] cf_d_in;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfmem_engine #(.CNT_W(8), .RESET_CYCLES(RST_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_attr(req_attr), .req_word(req_word),
        .req_addr(req_addr), .req_wdata(req_wdata), .cfg_setup(cfg_setup),
        .cfg_strobe_com(cfg_strobe_com), .cfg_strobe_attr(cfg_strobe_attr),
        .cfg_hold(cfg_hold), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .cf_reset(cf_reset), .cf_ready(cf_ready), .cf_wait_n(cf_wait_n),
        .cf_addr(cf_addr), .cf_ce1_n(cf_ce1_n), .cf_ce2_n(cf_ce2_n),
        .cf_reg_n(cf_reg_n), .cf_oe_n(cf_oe_n), .cf_we_n(cf_we_n),
        .cf_d_out(cf_d_out), .cf_d_oe(cf_d_oe), .cf_d_in(cf_d_in)
    );

    // card contents: a word per even address, differs per space
    function automatic logic [15:0] card_word(input logic attr, input logic [9:0] wa);
        logic [15:0] v;
        v = {wa[7:0] ^ 8'h3C, wa[9:2] ^ 8'hA5};
        return attr ? ~v : v;
    endfunction

    function automatic int clamp1(input logic [7:0] v);
        return (v == 8'd0) ? 1 : int'(v);
    endfunction

    // card model: byte accesses steer the selected byte onto D7:D0
    always_comb begin
        logic [15:0] m;
        m = card_word(!cf_reg_n, cf_addr[10:1]);
        if (!cf_oe_n && !cf_ce1_n) begin
            if (!cf_ce2_n) cf_d_in = m;
            else           cf_d_in = {8'hEE, cf_addr[0] ? m[15:8] : m[7:0]};
        end else begin
            cf_d_in = 16'hFFFF;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // one full transaction with a card-side wait run of wlen strobe cycles
    task automatic do_xfer(input logic wr, input logic attr, input logic word,
                           input logic [10:0] addr, input logic [15:0] wdata,
                           input int wlen, input bit poke_busy);
        int setup_n = 0, strobe_n = 0, hold_n = 0, sample = 0;
        bit seen = 0, bad_ctl = 0, bad_rdy = 0, bad_oe = 0, bad_dat = 0;
        logic [10:0] exp_addr;
        logic [15:0] m, exp_rd, exp_wd;
        int exp_strobe;
        exp_addr = word ? {addr[10:1], 1'b0} : addr;
        m = card_word(attr, addr[10:1]);
        exp_rd = word ? m : {8'h00, addr[0] ? m[15:8] : m[7:0]};
        exp_wd = word ? wdata : {8'h00, wdata[7:0]};
        exp_strobe = attr ? clamp1(cfg_strobe_attr) : clamp1(cfg_strobe_com);
        if (wlen + 1 > exp_strobe) exp_strobe = wlen + 1;

        @(negedge clk);
        req_write = wr; req_attr = attr; req_word = word;
        req_addr = addr; req_wdata = wdata; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = poke_busy;
        if (poke_busy) begin
            req_addr = ~addr; req_attr = !attr; req_word = !word;
        end
        forever begin
            sample++;
            if (sample == 3) req_valid = 1'b0;
            if (cf_ce1_n) break;
            if (req_ready) bad_rdy = 1;
            if (cf_addr !== exp_addr || cf_ce2_n !== !word || cf_reg_n !== !attr) bad_ctl = 1;
            if (!cf_oe_n || !cf_we_n) begin
                seen = 1;
                strobe_n++;
                if (cf_oe_n !== wr || cf_we_n !== !wr) bad_oe = 1;
                if (wr && cf_d_out !== exp_wd) bad_dat = 1;
                cf_wait_n = (strobe_n > wlen);
            end else begin
                cf_wait_n = 1'b1;
                if (seen) hold_n++; else setup_n++;
            end
            if (cf_d_oe !== !cf_we_n) bad_dat = 1;
            @(negedge clk);
        end
        cf_wait_n = 1'b1;
        check("R3 busy refusal / R5 R4 held controls", {30'd0, bad_rdy, bad_ctl}, 32'd0);
        check("R6 setup cycles", setup_n, clamp1(cfg_setup));
        check("R7 R8 strobe cycles", strobe_n, exp_strobe);
        check("R9 hold cycles", hold_n, clamp1(cfg_hold));
        check("R10 R11 strobe select", bad_oe, 0);
        check("R10 done at first idle cycle", rsp_done, 1'b1);
        if (wr) check("R11 write data / driver enable", bad_dat, 0);
        else    check("R10 read data", rsp_rdata, exp_rd);
        @(negedge clk);
        check("R10 done one cycle", rsp_done, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int rc, bad_q;
        logic [31:0] r;
        r = $urandom(32'd7731);
        // reset state
        #1;
        check("R1 reset held during rst_n", cf_reset, 1'b1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rc = 0; bad_q = 0;
        do begin
            @(negedge clk);
            rc++;
            if (cf_reset && (!cf_ce1_n || !cf_ce2_n || !cf_oe_n || !cf_we_n)) bad_q = 1;
        end while (cf_reset && rc < 1000);
        check("R1 reset length", rc, RST_CYC);
        check("R1 bus quiet in card reset", bad_q, 0);

        // boot: request offered while card busy
        req_valid = 1'b1; req_addr = 11'h155; req_attr = 1'b1;
        bad_q = 0;
        repeat (10) begin
            @(negedge clk);
            if (req_ready || !cf_ce1_n || !cf_oe_n || !cf_we_n) bad_q = 1;
        end
        check("R2 no cycle while card busy after reset", bad_q, 0);
        cf_ready = 1'b1;
        req_valid = 1'b0;

        // directed cases
        do_xfer(0, 0, 1, 11'h2A7, 16'h0, 0, 0);       // word read, common
        do_xfer(0, 0, 0, 11'h130, 16'h0, 0, 0);       // even byte
        do_xfer(0, 0, 0, 11'h131, 16'h0, 0, 0);       // odd byte
        do_xfer(0, 1, 0, 11'h00F, 16'h0, 0, 0);       // attribute odd byte, long strobe
        do_xfer(1, 0, 1, 11'h400, 16'hBEEF, 0, 0);    // word write
        do_xfer(1, 1, 0, 11'h021, 16'hC35A, 0, 0);    // attribute byte write
        do_xfer(0, 0, 1, 11'h066, 16'h0, 6, 0);       // wait longer than strobe
        cfg_strobe_com = 8'd5;
        do_xfer(0, 0, 0, 11'h067, 16'h0, 2, 0);       // wait shorter than strobe
        cfg_setup = 0; cfg_strobe_com = 0; cfg_hold = 0;
        do_xfer(1, 0, 0, 11'h7FF, 16'h1234, 0, 1);    // zero counts, request poked while busy
        cfg_setup = 3; cfg_hold = 4;
        do_xfer(0, 0, 1, 11'h3FE, 16'h0, 0, 1);

        // card goes busy while idle
        @(negedge clk);
        cf_ready = 1'b0; req_valid = 1'b1;
        bad_q = 0;
        repeat (6) begin
            @(negedge clk);
            if (req_ready || !cf_ce1_n) bad_q = 1;
        end
        check("R2 no cycle while card busy in idle", bad_q, 0);
        req_valid = 1'b0;
        cf_ready = 1'b1;

        // constrained random traffic
        for (int i = 0; i < 150; i++) begin
            cfg_setup       = 8'($urandom % 4);
            cfg_strobe_com  = 8'($urandom % 6);
            cfg_strobe_attr = 8'(20 + $urandom % 12);
            cfg_hold        = 8'($urandom % 4);
            do_xfer(1'($urandom), 1'($urandom % 4 == 0), 1'($urandom),
                    11'($urandom), 16'($urandom),
                    ($urandom % 2) ? int'($urandom % 8) : 0, 1'($urandom % 5 == 0));
        end
        finish_run();
    end

endmodule